// File: doc/BRIEF.md
# Alternating One-Place Buffer

This block holds a single data word and moves it from an input handshake to an output strobe in strict alternation. An internal phase bit decides what each enabled step does. In one phase the block offers to take a word from the input. In the other phase it presents the word it holds on the output and pulses output valid. A cycle with the step enable low is not a step: nothing happens and all state is held.

The phase bit is saved at the end of every successful step. The phase used by a step is the inverse of the saved value. After reset the saved value is 1, so the first enabled step is an output step that delivers the reset content of the cell, which is zero. A read step with no input word available fails. When a read fails, the saved phase is left alone and the next enabled step tries the read again. As a result, accepted words and output words strictly alternate. Words leave in the order they arrived, and none is lost or repeated.

Top module: `alt_buffer`

## Requirements
- R1: After reset the cell holds zero and the first enabled step is an output step, with out_valid_o=1, out_data_o=0 and in_ready_o=0.
- R2: In a cycle with step_i=0, in_ready_o=0 and out_valid_o=0, and the phase and the cell are unchanged.
- R3: In an output step, out_valid_o=1, out_data_o equals the stored word, and in_ready_o=0. The input is ignored in that step.
- R4: In a read step, in_ready_o=1 and out_valid_o=0.
- R5: A transfer happens when in_valid_i=1 and in_ready_o=1. The word is stored, and the next enabled step is an output step that carries that word.
- R6: A read step with in_valid_i=0 fails. The cell is unchanged and the next enabled step is again a read step.
- R7: After an output step, the next enabled step is a read step.
- R8: out_data_o changes only in the cycle after a transfer.
- R9: Under arbitrary stalls of the step enable and of the input, output words and accepted words strictly alternate, and each output word equals the most recently accepted word (zero before the first transfer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step enable; one step per cycle while high |
| in_valid_i | input | 1 | A word is offered on in_data_i |
| in_ready_o | output | 1 | Block accepts a word in this step |
| in_data_i | input | W | Input word |
| out_valid_o | output | 1 | Output strobe for this step |
| out_data_o | output | W | Stored word |

## Verification
in_ready_o and out_valid_o are combinational outputs of the current phase and step_i, so the bench checks them in the same cycle, after driving the inputs on the falling edge and before the next rising edge. A transfer updates the cell and the saved phase at the next rising edge. Its stored word therefore first appears on out_data_o during the next cycle. The vector table lists that value one row after the transfer. The random-stall phase samples each cycle before the edge and compares every output event against a reference of the last accepted word and the expected next event kind.

// File: rtl/alt_buf_pkg.sv
package alt_buf_pkg;
  typedef enum logic {
    PH_WRITE = 1'b0,
    PH_READ  = 1'b1
  } phase_e;
endpackage

// File: rtl/alt_buf_phase.sv
module alt_buf_phase
  import alt_buf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   advance_i,
  output phase_e phase_o
);
  logic saved_q;

  // step phase is the inverse of the value saved by the last successful step
  assign phase_o = phase_e'(~saved_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        saved_q <= 1'b1;
    else if (advance_i) saved_q <= logic'(phase_o);
  end
endmodule

// File: rtl/alt_buf_cell.sv
module alt_buf_cell #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/alt_buffer.sv
module alt_buffer
  import alt_buf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  phase_e phase;
  logic   xfer;
  logic   step_ok;

  assign in_ready_o  = step_i && (phase == PH_READ);
  assign out_valid_o = step_i && (phase == PH_WRITE);
  assign xfer        = in_ready_o && in_valid_i;
  // a read without data fails and leaves the saved phase alone
  assign step_ok     = out_valid_o || xfer;

  alt_buf_phase i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (step_ok),
    .phase_o   (phase)
  );

  alt_buf_cell #(.W(W)) i_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (xfer),
    .d_i    (in_data_i),
    .q_o    (out_data_o)
  );
endmodule

// File: rtl/alt_buffer_chk.sv
module alt_buffer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         step_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic [W-1:0] in_data_i,
  input logic         out_valid_o,
  input logic [W-1:0] out_data_o
);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> (!in_ready_o && !out_valid_o));

  a_r3_sides_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  a_r5_xfer_then_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && in_valid_i) |=> (!step_i || out_valid_o));

  a_r5_xfer_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && in_valid_i) |=> (out_data_o == $past(in_data_i)));

  a_r6_fail_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> (!step_i || in_ready_o));

  a_r7_out_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> (!step_i || in_ready_o));

  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && in_valid_i) |=> $stable(out_data_o));
endmodule

bind alt_buffer alt_buffer_chk #(.W(W)) i_alt_buffer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/test_alt_buffer.sv
module test_alt_buffer;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         step_i = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic         in_ready_o;
  logic         out_valid_o;
  logic [W-1:0] out_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  alt_buffer #(.W(W)) i_alt_buffer (
    .clk_i, .rst_ni, .step_i, .in_valid_i, .in_ready_o,
    .in_data_i, .out_valid_o, .out_data_o
  );

  typedef struct packed {
    logic         step;
    logic         iv;
    logic [W-1:0] d;
    logic         er;
    logic         eo;
    logic [W-1:0] ed;
  } vec_t;

  // step, in_valid, in_data, exp ready, exp out_valid, exp out_data
  localparam vec_t TBL [10] = '{
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00},  // R1 first step outputs zero
    '{1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 R7 read step, R6 fails
    '{1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 8'h00},  // R2 idle
    '{1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 8'h00},  // R6 retried read, R5 transfer
    '{1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'hA5},  // R3 R5 output, input ignored
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hA5},  // R2 R8 hold
    '{1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'hA5},  // R4 R8
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3C},  // R3
    '{1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 8'h3C},  // R5
    '{1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 8'hFF}   // R3
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic         exp_out;
    logic [W-1:0] last_acc;

    #20;
    chk("R1 reset out_valid", int'(out_valid_o), 0);
    chk("R1 reset out_data", int'(out_data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      step_i = TBL[i].step;
      in_valid_i = TBL[i].iv;
      in_data_i = TBL[i].d;
      #2;
      chk($sformatf("R3/R4 ready row %0d", i), int'(in_ready_o), int'(TBL[i].er));
      chk($sformatf("R3/R4 out_valid row %0d", i), int'(out_valid_o), int'(TBL[i].eo));
      chk($sformatf("R5/R8 out_data row %0d", i), int'(out_data_o), int'(TBL[i].ed));
    end

    // reset in the middle of traffic (R1)
    @(negedge clk_i);
    step_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step_i = 1'b1;
    in_valid_i = 1'b1;
    in_data_i = 8'h77;
    #2;
    chk("R1 after reset out_valid", int'(out_valid_o), 1);
    chk("R1 after reset out_data", int'(out_data_o), 0);
    chk("R1 after reset ready", int'(in_ready_o), 0);

    // random stalls: strict alternation and order (R9)
    exp_out = 1'b0;  // output step just taking place
    last_acc = '0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk_i);
      step_i = 1'($urandom_range(0, 3) != 0);
      in_valid_i = 1'($urandom_range(0, 1));
      in_data_i = W'($urandom);
      #2;
      if (out_valid_o) begin
        chk("R9 output when expected", int'(exp_out), 1);
        chk("R9 output word order", int'(out_data_o), int'(last_acc));
        exp_out = 1'b0;
      end
      if (in_ready_o && in_valid_i) begin
        chk("R9 accept when expected", int'(exp_out), 0);
        last_acc = in_data_i;
        exp_out = 1'b1;
      end
    end
    done = 1;
    finish_run();
  end
endmodule